// File: doc/BRIEF.md
# Priority-Grouped Free Channel Allocator

This block keeps track of which physical DMA channels are in use and hands out a free one whenever a requester asks. The channels are sorted into four priority levels, and the level of a channel comes from bits 3:2 of its index. As a result, two separate index ranges share each level. When a requester asks for a channel, the block returns the free channel with the best level. If nothing eligible is free, it returns a failure flag instead. A requester that finishes with a channel gives it back by presenting that channel's index on the release strobe.

The allocation response is combinational: it appears in the same cycle as the allocate strobe. The busy bitmap is a register. It takes on the effect of a grant or a release at the next rising clock edge. The channel count is a parameter, and it also limits which priority levels take part in the search.

Top module: `challoc_top`

## Requirements
- R1: While reset is held, and after it is released, `busy_map` reads all zeros, so every channel is free.
- R2: A channel's level is (index mod 16) >> 2, which is index bits 3:2. The search tries level 0 first, then 1, then 2, then 3, and takes the first level that has a free channel. For example, with 32 channels, level 0 holds channels 0–3 and 16–19.
- R3: Inside the chosen level, the grant goes to the free channel with the lowest index, so channel 3 is chosen before channel 16.
- R4: Only levels 0 through ((NUM_CH−1) mod 16) >> 2 are searched. With NUM_CH = 20 only level 0 is searched, so only channels 0–3 and 16–19 can ever be granted.
- R5: If `alloc_req` is high and no searched channel is free, `grant_fail` is 1 and `grant_valid` is 0 in that cycle, and `busy_map` does not change.
- R6: If `alloc_req` is high and a channel is granted, `grant_valid` is 1 and `grant_idx` carries the index in that same cycle. That channel's bit in `busy_map` is set from the next cycle on, so back-to-back allocations never get the same index.
- R7: A release of a busy channel clears its bit in `busy_map` at the next edge. A release of a channel that is already free leaves `busy_map` unchanged.
- R8: If a release and an allocation arrive in the same cycle, the release is applied first. The released channel can therefore be granted by that same allocation.
- R9: When `alloc_req` is low, `grant_valid` and `grant_fail` are both 0. When neither strobe is high, `busy_map` holds. A release index of NUM_CH or more has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_req | input | 1 | Allocate strobe, one cycle per request |
| grant_valid | output | 1 | A channel was granted this cycle |
| grant_fail | output | 1 | The request found no free channel |
| grant_idx | output | IDX_W | Index of the granted channel, zero when no grant |
| rel_req | input | 1 | Release strobe |
| rel_idx | input | IDX_W | Index of the channel being released |
| busy_map | output | NUM_CH | One bit per channel, 1 when the channel is in use |

## Verification
The grant response appears in the same cycle as the strobe, with no register in its path. The resulting `busy_map` change appears one clock edge later. The bench drives a strobe at a falling edge and compares the response 3 ns later, still within that cycle. Each scoreboard entry also holds the `busy_map` value expected before its own operation takes effect, which is the result of the previous operation one edge earlier. A second instance with 20 channels checks the level cut-off and out-of-range releases with the same timing.

// File: rtl/challoc_pkg.sv
package challoc_pkg;
  // Index bits that select the priority level
  localparam int LVL_LSB  = 2;
  localparam int LVL_W    = 2;
  localparam int NUM_LVL  = 1 << LVL_W;
  localparam int GRP_SPAN = 1 << (LVL_LSB + LVL_W);

  // Priority level of a channel index
  function automatic int level_of(int idx);
    return (idx % GRP_SPAN) >> LVL_LSB;
  endfunction

  // Last level that takes part in the search for a given channel count
  function automatic int top_level(int n);
    return ((n - 1) % GRP_SPAN) >> LVL_LSB;
  endfunction
endpackage

// File: rtl/challoc_track.sv
module challoc_track #(
  parameter int NUM_CH = 32,
  parameter int IDX_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rel_req,
  input  logic [IDX_W-1:0]  rel_idx,
  input  logic              grant_valid,
  input  logic [IDX_W-1:0]  grant_idx,
  output logic [NUM_CH-1:0] busy_q,
  output logic [NUM_CH-1:0] free_eff
);
  logic [NUM_CH-1:0] rel_mask;
  logic [NUM_CH-1:0] grant_mask;
  logic [NUM_CH-1:0] kept;

  always_comb begin
    for (int i = 0; i < NUM_CH; i++) begin
      rel_mask[i]   = rel_req && (rel_idx == IDX_W'(i));
      grant_mask[i] = grant_valid && (grant_idx == IDX_W'(i));
    end
  end

  // Release is applied before the allocation search sees the map
  assign kept     = busy_q & ~rel_mask;
  assign free_eff = ~kept;

  always_ff @(posedge clk) begin
    if (!rst_n) busy_q <= '0;
    else        busy_q <= kept | grant_mask;
  end
endmodule

// File: rtl/challoc_lvl_pick.sv
module challoc_lvl_pick
  import challoc_pkg::*;
#(
  parameter int NUM_CH = 32,
  parameter int IDX_W  = 5,
  parameter int LEVEL  = 0
) (
  input  logic [NUM_CH-1:0] free_eff,
  output logic              hit,
  output logic [IDX_W-1:0]  idx
);
  // Descending scan leaves the lowest free index of this level
  always_comb begin
    hit = 1'b0;
    idx = '0;
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (level_of(i) == LEVEL && free_eff[i]) begin
        hit = 1'b1;
        idx = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/challoc_lvl_sel.sv
module challoc_lvl_sel #(
  parameter int NLVL  = 4,
  parameter int IDX_W = 5
) (
  input  logic [NLVL-1:0]       hit_vec,
  input  logic [NLVL*IDX_W-1:0] idx_flat,
  output logic                  any_hit,
  output logic [IDX_W-1:0]      sel_idx
);
  // Lowest level number wins
  always_comb begin
    any_hit = 1'b0;
    sel_idx = '0;
    for (int l = NLVL - 1; l >= 0; l--) begin
      if (hit_vec[l]) begin
        any_hit = 1'b1;
        sel_idx = idx_flat[l*IDX_W +: IDX_W];
      end
    end
  end
endmodule

// File: rtl/challoc_top.sv
module challoc_top
  import challoc_pkg::*;
#(
  parameter int NUM_CH = 32,
  parameter int IDX_W  = $clog2(NUM_CH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_req,
  output logic              grant_valid,
  output logic              grant_fail,
  output logic [IDX_W-1:0]  grant_idx,
  input  logic              rel_req,
  input  logic [IDX_W-1:0]  rel_idx,
  output logic [NUM_CH-1:0] busy_map
);
  localparam int TOP_LVL = top_level(NUM_CH);
  localparam int NLVL    = TOP_LVL + 1;

  logic [NUM_CH-1:0]     free_eff;
  logic [NUM_CH-1:0]     busy_q;
  logic [NLVL-1:0]       lvl_hit;
  logic [NLVL*IDX_W-1:0] lvl_idx_flat;
  logic                  search_hit;
  logic [IDX_W-1:0]      search_idx;

  challoc_track #(.NUM_CH(NUM_CH), .IDX_W(IDX_W)) u_track (
    .clk         (clk),
    .rst_n       (rst_n),
    .rel_req     (rel_req),
    .rel_idx     (rel_idx),
    .grant_valid (grant_valid),
    .grant_idx   (grant_idx),
    .busy_q      (busy_q),
    .free_eff    (free_eff)
  );

  for (genvar l = 0; l < NLVL; l++) begin : g_lvl
    challoc_lvl_pick #(.NUM_CH(NUM_CH), .IDX_W(IDX_W), .LEVEL(l)) u_pick (
      .free_eff (free_eff),
      .hit      (lvl_hit[l]),
      .idx      (lvl_idx_flat[l*IDX_W +: IDX_W])
    );
  end

  challoc_lvl_sel #(.NLVL(NLVL), .IDX_W(IDX_W)) u_sel (
    .hit_vec  (lvl_hit),
    .idx_flat (lvl_idx_flat),
    .any_hit  (search_hit),
    .sel_idx  (search_idx)
  );

  assign grant_valid = alloc_req && search_hit;
  assign grant_fail  = alloc_req && !search_hit;
  assign grant_idx   = grant_valid ? search_idx : '0;
  assign busy_map    = busy_q;
endmodule

// File: rtl/challoc_chk.sv
module challoc_chk
  import challoc_pkg::*;
#(
  parameter int NUM_CH = 32,
  parameter int IDX_W  = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              alloc_req,
  input logic              grant_valid,
  input logic              grant_fail,
  input logic [IDX_W-1:0]  grant_idx,
  input logic              rel_req,
  input logic [IDX_W-1:0]  rel_idx,
  input logic [NUM_CH-1:0] busy_map
);
  localparam logic [IDX_W:0] CH_LIM = (IDX_W+1)'(NUM_CH);

  logic [NUM_CH-1:0] search_mask;
  logic [NUM_CH-1:0] rel_vec;
  logic              rel_in_range;

  always_comb begin
    for (int i = 0; i < NUM_CH; i++) begin
      search_mask[i] = level_of(i) <= top_level(NUM_CH);
      rel_vec[i]     = rel_req && (rel_idx == IDX_W'(i));
    end
  end
  assign rel_in_range = {1'b0, rel_idx} < CH_LIM;

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    !rst_n |=> busy_map == '0);

  // R6
  resp_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_req |-> (grant_valid != grant_fail));

  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !alloc_req |-> (!grant_valid && !grant_fail));

  // R8
  grant_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    grant_valid |-> (!busy_map[grant_idx] || (rel_req && rel_idx == grant_idx)));

  // R6
  grant_marks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    grant_valid |=> busy_map[$past(grant_idx)]);

  // R7
  release_frees_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rel_req && rel_in_range && !(grant_valid && grant_idx == rel_idx))
      |=> !busy_map[$past(rel_idx)]);

  // R5
  fail_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    grant_fail |-> (((busy_map & ~rel_vec) & search_mask) == search_mask));

  // R5
  fail_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_fail && !rel_req) |=> $stable(busy_map));

  // R9
  quiet_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!alloc_req && !rel_req) |=> $stable(busy_map));
endmodule

bind challoc_top challoc_chk #(.NUM_CH(NUM_CH), .IDX_W(IDX_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .alloc_req   (alloc_req),
  .grant_valid (grant_valid),
  .grant_fail  (grant_fail),
  .grant_idx   (grant_idx),
  .rel_req     (rel_req),
  .rel_idx     (rel_idx),
  .busy_map    (busy_map)
);

// File: tb/test_challoc_top.sv
module test_challoc_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        alloc_req = 1'b0;
  logic        rel_req = 1'b0;
  logic [4:0]  rel_idx = '0;
  logic        grant_valid, grant_fail;
  logic [4:0]  grant_idx;
  logic [31:0] busy_map;

  logic        s_alloc = 1'b0;
  logic        s_rel = 1'b0;
  logic [4:0]  s_rel_idx = '0;
  logic        s_valid, s_fail;
  logic [4:0]  s_idx;
  logic [19:0] s_busy;

  int checks = 0;
  int errs = 0;
  bit done = 0;

  always #5 clk = ~clk;

  challoc_top #(.NUM_CH(32)) i_challoc_top (
    .clk(clk), .rst_n(rst_n), .alloc_req(alloc_req),
    .grant_valid(grant_valid), .grant_fail(grant_fail), .grant_idx(grant_idx),
    .rel_req(rel_req), .rel_idx(rel_idx), .busy_map(busy_map));

  challoc_top #(.NUM_CH(20)) i_challoc_top_n20 (
    .clk(clk), .rst_n(rst_n), .alloc_req(s_alloc),
    .grant_valid(s_valid), .grant_fail(s_fail), .grant_idx(s_idx),
    .rel_req(s_rel), .rel_idx(s_rel_idx), .busy_map(s_busy));

  typedef struct {
    bit          valid;
    bit          fail;
    int          idx;
    logic [31:0] busy_before;
    string       tag;
  } item_t;

  item_t       sb_q[$];
  logic [31:0] m_busy = '0;

  // Reference search: levels in order, lowest index inside a level
  function automatic int pick(logic [31:0] b, int n);
    for (int lvl = 0; lvl <= ((n - 1) % 16) / 4; lvl++)
      for (int i = 0; i < n; i++)
        if (((i % 16) / 4) == lvl && !b[i]) return i;
    return -1;
  endfunction

  task automatic check(bit ok, string tag, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // Driver: called at a falling edge, returns at the next one
  task automatic op(bit a, bit r, int ri, string tag);
    item_t       it;
    logic [31:0] b;
    int          p;
    alloc_req = a;
    rel_req   = r;
    rel_idx   = 5'(ri);
    b = m_busy;
    if (r && ri < 32) b[ri] = 1'b0;
    p = a ? pick(b, 32) : -1;
    it.valid = a && (p >= 0);
    it.fail  = a && (p < 0);
    it.idx   = p;
    it.busy_before = m_busy;
    it.tag   = tag;
    sb_q.push_back(it);
    if (p >= 0) b[p] = 1'b1;
    m_busy = b;
    @(negedge clk);
  endtask

  // Monitor: compares 3 ns after each falling edge
  initial begin
    forever begin
      @(negedge clk);
      #3;
      if (sb_q.size() > 0) begin
        item_t it;
        it = sb_q.pop_front();
        check(grant_valid == it.valid && grant_fail == it.fail, it.tag,
              "valid/fail", {grant_valid, grant_fail}, {it.valid, it.fail});
        if (it.valid)
          check(int'(grant_idx) == it.idx, it.tag, "grant_idx", grant_idx, it.idx);
        check(busy_map == it.busy_before, it.tag, "busy_map", busy_map, it.busy_before);
      end
    end
  end

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, errs);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errs++;
      $display("FAIL watchdog: actual hung expected done");
      finish_up();
    end
  end

  initial begin
    logic [31:0] sm;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    check(busy_map == '0, "R1", "busy_map in reset", busy_map, 0);
    check(s_busy == '0, "R1", "n20 busy_map in reset", s_busy, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(busy_map == '0, "R1", "busy_map after reset", busy_map, 0);

    op(0, 0, 0, "R9");
    for (int k = 0; k < 32; k++) op(1, 0, 0, "R2 R3 R6");
    op(1, 0, 0, "R5");
    op(0, 1, 21, "R7");
    op(1, 0, 0, "R2");
    op(0, 1, 5, "R7");
    op(0, 1, 17, "R7");
    op(1, 0, 0, "R2");
    op(1, 0, 0, "R3");
    op(0, 1, 9, "R7");
    op(0, 1, 9, "R7");
    op(1, 0, 0, "R6");
    op(1, 0, 0, "R5");
    op(1, 1, 30, "R8");
    op(0, 1, 2, "R7");
    op(0, 1, 0, "R7");
    op(1, 0, 0, "R3");
    op(1, 0, 0, "R3");
    op(0, 0, 0, "R9");
    op(0, 0, 0, "R9");
    alloc_req = 1'b0;
    rel_req = 1'b0;
    repeat (2) @(negedge clk);

    // R4: 20-channel instance searches level 0 only
    sm = '0;
    for (int k = 0; k < 10; k++) begin
      int p;
      s_alloc = 1'b1;
      p = pick(sm, 20);
      #3;
      check(s_valid == (p >= 0) && s_fail == (p < 0), "R4", "n20 valid/fail",
            {s_valid, s_fail}, {p >= 0, p < 0});
      if (p >= 0) begin
        check(int'(s_idx) == p, "R4", "n20 grant_idx", s_idx, p);
        sm[p] = 1'b1;
      end
      @(negedge clk);
    end
    s_alloc = 1'b0;
    check(s_busy == sm[19:0], "R4", "n20 busy_map", s_busy, sm[19:0]);
    // R9: release index beyond the channel count changes nothing
    s_rel = 1'b1;
    s_rel_idx = 5'd25;
    @(negedge clk);
    s_rel = 1'b0;
    @(negedge clk);
    check(s_busy == sm[19:0], "R9", "n20 busy_map after out-of-range release",
          s_busy, sm[19:0]);

    done = 1;
    finish_up();
  end
endmodule